// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block turns one requested SMBus transaction into the ordered list of byte-level bus operations that a separate bit engine carries out: start (also used as a repeated start), write one byte, read one byte, and stop. A client hands over the whole command in one valid/ready handshake. It supplies the protocol code, the 7-bit target address, one or two command bytes, a byte count and up to `MAX_BLK` bytes of write data. The sequencer then walks the frame for that protocol one operation at a time. Each byte read from the target is passed back on a strobe with its index. A one-cycle completion pulse marks the end of the transaction and carries an error flag and the phase that failed.

The framings cover quick, byte, byte-data, word-data, process call, counted block read and block write, and the raw block read and write forms with no count byte. The command phase and the read phase are joined by a repeated start, with no stop in between. A counted block read takes its length from the first byte the target returns. Words travel low byte first. If an address or host-written byte is not acknowledged, the sequencer ends the frame with a stop and reports the failing phase.

Top module: `smbus_cmd_seq`

## Requirements
- R1: `cmd_ready_o` is high only when idle, and a command is taken when `cmd_valid_i` and `cmd_ready_o` are both high. `done_o` is a single-cycle pulse, and `cmd_ready_o` is high again in the cycle after it. Out of reset, `cmd_ready_o`=1 while `done_o` and `prim_req_o` are 0.
- R2: `prim_req_o` stays high with `prim_op_o` and `prim_wdata_o` stable until `prim_done_i`. Each `prim_done_i` completes exactly one operation. Op codes are 0 start, 1 stop, 2 write byte and 3 read byte. Every transaction opens with a start and closes with a stop.
- R3: An address byte is `{addr[6:0], dir}`, with dir 1 for read and 0 for write.
- R4: Protocol 0 (quick) issues start, the address with dir = `cmd_wdata_i[0]`, then stop. Protocol 1 (read byte) issues start, address+read, one read and stop. Protocol 2 (write byte) issues start, address+write, data byte 0 and stop.
- R5: Protocols 5 and 6 (write byte/word data) issue start, address+write, the command byte, one or two data bytes and stop. Protocols 3 and 4 (read byte/word data) issue start, address+write, the command byte, a repeated start, address+read, one or two reads and stop. Word data is low byte first: write byte 0 goes before byte 1, and read index 0 is the low byte.
- R6: Protocol 7 (process call) issues start, address+write, command, data bytes 0 and 1, a repeated start, address+read, two reads and stop. There is no stop between the phases.
- R7: Every read is answered with ACK (`prim_nack_o`=0) except the last read of the frame, which has `prim_nack_o`=1.
- R8: Protocol 8 (block read) issues start, address+write, command, a repeated start and address+read. It then reads a count byte and that many data bytes. A count above 32 is taken as 32 and a count of 0 as 1. The count byte is not delivered on the read port.
- R9: Protocol 12 is not used. Protocol 9 (block write) issues start, address+write, command, a count byte equal to min(`cmd_len_i`, 32), that many data bytes and stop. Byte k is `cmd_wdata_i[8k+7:8k]`.
- R10: Protocol 10 (raw block read) issues start, address+write, the command byte, then `cmd_code2_i` as well when `cmd_two_i`=1. It follows with a repeated start, address+read, and min(max(`cmd_len_i`, 1), 32) reads with no count byte, then stop.
- R11: Protocol 11 (raw block write) issues start, address+write, the command byte, min(`cmd_len_i`, 32) data bytes with no count byte, and stop.
- R12: When an address or host-written byte gets `prim_ack_i`=0, the next operation is a stop, and `done_o` follows with `err_o`=1. `err_phase_o` is 1 for an address, 2 for a command byte and 3 for a count or data byte. A clean transaction ends with `err_o`=0 and `err_phase_o`=0.
- R13: Each delivered read byte gives one `rd_valid_o` pulse with `rd_data_o` and `rd_idx_o`, which counts 0, 1, 2, … within the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted |
| cmd_proto_i | input | 4 | Protocol code 0..11 |
| cmd_addr_i | input | 7 | Target address |
| cmd_code_i | input | 8 | First command byte |
| cmd_code2_i | input | 8 | Second command byte (raw block read) |
| cmd_two_i | input | 1 | Send second command byte |
| cmd_len_i | input | 8 | Host byte count |
| cmd_wdata_i | input | MAX_BLK*8 | Write data, byte k at bits 8k+7:8k |
| done_o | output | 1 | Transaction complete pulse |
| err_o | output | 1 | Transaction ended on a NACK |
| err_phase_o | output | 2 | Failing phase: 0 none, 1 address, 2 command, 3 data |
| rd_valid_o | output | 1 | Read byte strobe |
| rd_data_o | output | 8 | Read byte |
| rd_idx_o | output | 8 | Read byte index |
| prim_req_o | output | 1 | Operation request to bit engine |
| prim_op_o | output | 2 | Operation: 0 start, 1 stop, 2 write, 3 read |
| prim_wdata_o | output | 8 | Byte to write |
| prim_nack_o | output | 1 | Answer this read with NACK |
| prim_done_i | input | 1 | Operation complete |
| prim_ack_i | input | 1 | Target acknowledged the written byte |
| prim_rdata_i | input | 8 | Byte read from target |

## Verification
Two events can land in the same cycle. One is a NACK on the final host-written byte of a frame. The other is the normal step from that byte to the stop, or to the repeated start. Both exits lead to a stop, so a design that merges them wrongly can drop the error or issue a second stop. The bench arms the model bit engine to NACK a chosen write index, including the last one of word and block writes. It then judges the logged operation list, which must end in exactly one stop directly after the failing byte, together with `err_o` and `err_phase_o` at the completion pulse.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;
  localparam int unsigned CNT_W = 8;

  typedef enum logic [3:0] {
    PR_QUICK    = 4'd0,
    PR_RD_BYTE  = 4'd1,
    PR_WR_BYTE  = 4'd2,
    PR_RD_BDATA = 4'd3,
    PR_RD_WORD  = 4'd4,
    PR_WR_BDATA = 4'd5,
    PR_WR_WORD  = 4'd6,
    PR_PROC     = 4'd7,
    PR_BLK_RD   = 4'd8,
    PR_BLK_WR   = 4'd9,
    PR_RAW_RD   = 4'd10,
    PR_RAW_WR   = 4'd11
  } proto_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD1, S_CMD2, S_WCNT, S_WDATA,
    S_RSTART, S_RADDR, S_RCNT, S_RDATA, S_STOP, S_FIN
  } st_e;

  // frame shape derived from protocol
  typedef struct packed {
    logic             quick;
    logic             first_rd;
    logic [1:0]       n_cmd;
    logic             wr_cnt;
    logic [CNT_W-1:0] n_wr;
    logic             rs;
    logic             rd_cnt;
    logic [CNT_W-1:0] n_rd;
  } frame_t;
endpackage

// File: rtl/smbus_seq_decode.sv
module smbus_seq_decode
  import smbus_seq_pkg::*;
#(
  parameter int unsigned MAX_BLK = 32
) (
  input  logic [3:0]       proto_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             two_i,
  output frame_t           frame_o
);
  localparam logic [CNT_W-1:0] MaxLen = CNT_W'(MAX_BLK);

  logic [CNT_W-1:0] len_wr, len_rd;

  always_comb begin
    len_wr  = (len_i > MaxLen) ? MaxLen : len_i;
    len_rd  = (len_wr == '0) ? CNT_W'(1) : len_wr;
    frame_o = '0;
    case (proto_e'(proto_i))
      PR_RD_BYTE: begin
        frame_o.first_rd = 1'b1;
        frame_o.n_rd     = CNT_W'(1);
      end
      PR_WR_BYTE: frame_o.n_wr = CNT_W'(1);
      PR_RD_BDATA, PR_RD_WORD: begin
        frame_o.n_cmd = 2'd1;
        frame_o.rs    = 1'b1;
        frame_o.n_rd  = (proto_i == PR_RD_WORD) ? CNT_W'(2) : CNT_W'(1);
      end
      PR_WR_BDATA, PR_WR_WORD: begin
        frame_o.n_cmd = 2'd1;
        frame_o.n_wr  = (proto_i == PR_WR_WORD) ? CNT_W'(2) : CNT_W'(1);
      end
      PR_PROC: begin
        frame_o.n_cmd = 2'd1;
        frame_o.n_wr  = CNT_W'(2);
        frame_o.rs    = 1'b1;
        frame_o.n_rd  = CNT_W'(2);
      end
      PR_BLK_RD: begin
        frame_o.n_cmd  = 2'd1;
        frame_o.rs     = 1'b1;
        frame_o.rd_cnt = 1'b1;
      end
      PR_BLK_WR: begin
        frame_o.n_cmd  = 2'd1;
        frame_o.wr_cnt = 1'b1;
        frame_o.n_wr   = len_wr;
      end
      PR_RAW_RD: begin
        frame_o.n_cmd = two_i ? 2'd2 : 2'd1;
        frame_o.rs    = 1'b1;
        frame_o.n_rd  = len_rd;
      end
      PR_RAW_WR: begin
        frame_o.n_cmd = 2'd1;
        frame_o.n_wr  = len_wr;
      end
      default: frame_o.quick = 1'b1;
    endcase
  end
endmodule

// File: rtl/smbus_seq_idx.sv
module smbus_seq_idx
  import smbus_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W:0]   idx_nx;

  assign idx_nx = {1'b0, idx_q} + (CNT_W+1)'(1);
  assign last_o = (idx_nx == {1'b0, lim_i});
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (inc_i)  idx_q <= idx_nx[CNT_W-1:0];
  end

  // R13: byte index never steps past the frame length
  a_r13_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (idx_nx < {1'b0, lim_i}));
endmodule

// File: rtl/smbus_cmd_seq.sv
module smbus_cmd_seq
  import smbus_seq_pkg::*;
#(
  parameter int unsigned MAX_BLK = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [3:0]           cmd_proto_i,
  input  logic [6:0]           cmd_addr_i,
  input  logic [7:0]           cmd_code_i,
  input  logic [7:0]           cmd_code2_i,
  input  logic                 cmd_two_i,
  input  logic [7:0]           cmd_len_i,
  input  logic [MAX_BLK*8-1:0] cmd_wdata_i,
  output logic                 done_o,
  output logic                 err_o,
  output logic [1:0]           err_phase_o,
  output logic                 rd_valid_o,
  output logic [7:0]           rd_data_o,
  output logic [7:0]           rd_idx_o,
  output logic                 prim_req_o,
  output logic [1:0]           prim_op_o,
  output logic [7:0]           prim_wdata_o,
  output logic                 prim_nack_o,
  input  logic                 prim_done_i,
  input  logic                 prim_ack_i,
  input  logic [7:0]           prim_rdata_i
);
  localparam int unsigned IDX_W = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1;
  localparam int unsigned WD_W  = MAX_BLK * 8;
  localparam logic [CNT_W-1:0] MaxLen = CNT_W'(MAX_BLK);

  st_e              state_q, state_d;
  logic [3:0]       proto_q;
  logic [6:0]       addr_q;
  logic [7:0]       code_q, code2_q;
  logic             two_q;
  logic [CNT_W-1:0] len_q, blk_len_q;
  logic [WD_W-1:0]  wdata_q;
  logic             err_q;
  phase_e           phase_q;
  logic             rd_valid_q;
  logic [7:0]       rd_data_q;
  logic [CNT_W-1:0] rd_idx_q;

  frame_t           fr;
  logic [CNT_W-1:0] idx, lim, rd_lim;
  logic             idx_last, idx_clr, idx_inc, stay;
  logic             accept, wr_op, nack_hit;
  st_e              from_addr, from_cmd1, from_cmd2, from_wcnt, from_wdata;
  op_e              op;
  logic [7:0]       wbyte [MAX_BLK];

  for (genvar g = 0; g < int'(MAX_BLK); g++) begin : g_wbyte
    assign wbyte[g] = wdata_q[8*g +: 8];
  end

  smbus_seq_decode #(.MAX_BLK(MAX_BLK)) u_dec (
    .proto_i(proto_q), .len_i(len_q), .two_i(two_q), .frame_o(fr)
  );

  assign rd_lim = fr.rd_cnt ? blk_len_q : fr.n_rd;
  assign lim    = (state_q == S_WDATA) ? fr.n_wr : rd_lim;

  smbus_seq_idx u_idx (
    .clk_i, .rst_ni, .clr_i(idx_clr), .inc_i(idx_inc), .lim_i(lim),
    .idx_o(idx), .last_o(idx_last)
  );

  assign accept   = cmd_valid_i && (state_q == S_IDLE);
  assign wr_op    = state_q inside {S_ADDR, S_RADDR, S_CMD1, S_CMD2, S_WCNT, S_WDATA};
  assign nack_hit = prim_done_i && wr_op && !prim_ack_i;
  assign stay     = prim_done_i && !nack_hit && !idx_last &&
                    (state_q inside {S_WDATA, S_RDATA});
  assign idx_inc  = stay;
  assign idx_clr  = prim_done_i && !stay;

  // stage skipping chain
  always_comb begin
    from_wdata = fr.rs ? S_RSTART : S_STOP;
    from_wcnt  = (fr.n_wr != '0) ? S_WDATA : from_wdata;
    from_cmd2  = fr.wr_cnt ? S_WCNT : from_wcnt;
    from_cmd1  = (fr.n_cmd == 2'd2) ? S_CMD2 : from_cmd2;
    from_addr  = fr.first_rd ? S_RDATA :
                 (fr.n_cmd != 2'd0) ? S_CMD1 : from_cmd2;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (accept) state_d = S_START;
      S_FIN:    state_d = S_IDLE;
      default: if (prim_done_i) begin
        case (state_q)
          S_START:  state_d = S_ADDR;
          S_ADDR:   state_d = from_addr;
          S_CMD1:   state_d = from_cmd1;
          S_CMD2:   state_d = from_cmd2;
          S_WCNT:   state_d = from_wcnt;
          S_WDATA:  state_d = idx_last ? from_wdata : S_WDATA;
          S_RSTART: state_d = S_RADDR;
          S_RADDR:  state_d = fr.rd_cnt ? S_RCNT : S_RDATA;
          S_RCNT:   state_d = S_RDATA;
          S_RDATA:  state_d = idx_last ? S_STOP : S_RDATA;
          default:  state_d = S_FIN;
        endcase
        if (nack_hit) state_d = S_STOP;
      end
    endcase
  end

  always_comb begin
    op           = OP_WRITE;
    prim_wdata_o = '0;
    prim_req_o   = !(state_q inside {S_IDLE, S_FIN});
    case (state_q)
      S_START, S_RSTART: op = OP_START;
      S_STOP:            op = OP_STOP;
      S_RCNT, S_RDATA:   op = OP_READ;
      S_ADDR:  prim_wdata_o = {addr_q, fr.quick ? wbyte[0][0] : fr.first_rd};
      S_RADDR: prim_wdata_o = {addr_q, 1'b1};
      S_CMD1:  prim_wdata_o = code_q;
      S_CMD2:  prim_wdata_o = code2_q;
      S_WCNT:  prim_wdata_o = fr.n_wr;
      S_WDATA: prim_wdata_o = wbyte[idx[IDX_W-1:0]];
      default: ;
    endcase
  end

  assign prim_op_o   = op;
  assign prim_nack_o = (state_q == S_RDATA) && idx_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      proto_q    <= '0;
      addr_q     <= '0;
      code_q     <= '0;
      code2_q    <= '0;
      two_q      <= 1'b0;
      len_q      <= '0;
      wdata_q    <= '0;
      blk_len_q  <= CNT_W'(1);
      err_q      <= 1'b0;
      phase_q    <= PH_NONE;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      rd_idx_q   <= '0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= 1'b0;
      if (accept) begin
        proto_q <= cmd_proto_i;
        addr_q  <= cmd_addr_i;
        code_q  <= cmd_code_i;
        code2_q <= cmd_code2_i;
        two_q   <= cmd_two_i;
        len_q   <= cmd_len_i;
        wdata_q <= cmd_wdata_i;
        err_q   <= 1'b0;
        phase_q <= PH_NONE;
      end
      if (nack_hit) begin
        err_q <= 1'b1;
        case (state_q)
          S_ADDR, S_RADDR: phase_q <= PH_ADDR;
          S_CMD1, S_CMD2:  phase_q <= PH_CMD;
          default:         phase_q <= PH_DATA;
        endcase
      end
      // device count byte, clamped to 1..MAX_BLK
      if (prim_done_i && state_q == S_RCNT)
        blk_len_q <= (prim_rdata_i == '0) ? CNT_W'(1) :
                     (prim_rdata_i > MaxLen) ? MaxLen : prim_rdata_i;
      if (prim_done_i && state_q == S_RDATA) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= prim_rdata_i;
        rd_idx_q   <= idx;
      end
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign err_o       = err_q;
  assign err_phase_o = phase_q;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign rd_idx_o    = rd_idx_q;

  // R1: completion is one cycle wide and the port reopens
  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && cmd_ready_o));
  // R2: request and its payload hold until the engine completes
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_req_o && !prim_done_i) |=>
      (prim_req_o && $stable(prim_op_o) && $stable(prim_wdata_o)));
  // R7: NACK request only on a read
  a_r7_nack_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_nack_o |-> (prim_req_o && prim_op_o == OP_READ));
  // R8: clamped block length
  a_r8_blk_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RDATA && fr.rd_cnt) |-> (blk_len_q != '0 && blk_len_q <= MaxLen));
  // R12: a missed acknowledge on a write leads straight to stop
  a_r12_nack_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_req_o && prim_done_i && prim_op_o == OP_WRITE && !prim_ack_i) |=>
      (prim_req_o && prim_op_o == OP_STOP));
  // R12: error flag and phase agree at completion
  a_r12_phase_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o == (err_phase_o != PH_NONE)));
endmodule

// File: tb/smbus_cmd_seq_tb_top.sv
module smbus_cmd_seq_tb_top;
  localparam int MAXB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            cmd_valid = 1'b0, cmd_ready;
  logic [3:0]      t_proto = '0;
  logic [6:0]      t_addr = '0;
  logic [7:0]      t_code = '0, t_code2 = '0, t_len = '0;
  logic            t_two = 1'b0;
  logic [MAXB*8-1:0] t_wdata = '0;
  logic            done, err;
  logic [1:0]      err_ph;
  logic            rd_valid;
  logic [7:0]      rd_data, rd_idx;
  logic            p_req, p_nack;
  logic [1:0]      p_op;
  logic [7:0]      p_wdata;
  logic            p_done = 1'b0, p_ack = 1'b1;
  logic [7:0]      p_rdata = '0;

  smbus_cmd_seq #(.MAX_BLK(MAXB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_proto_i(t_proto), .cmd_addr_i(t_addr), .cmd_code_i(t_code),
    .cmd_code2_i(t_code2), .cmd_two_i(t_two), .cmd_len_i(t_len),
    .cmd_wdata_i(t_wdata),
    .done_o(done), .err_o(err), .err_phase_o(err_ph),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_idx_o(rd_idx),
    .prim_req_o(p_req), .prim_op_o(p_op), .prim_wdata_o(p_wdata),
    .prim_nack_o(p_nack), .prim_done_i(p_done), .prim_ack_i(p_ack),
    .prim_rdata_i(p_rdata)
  );

  int total = 0, bad = 0;

  // expected and observed operation logs
  logic [1:0] e_op [0:99];
  logic [7:0] e_by [0:99];
  logic       e_nk [0:99];
  int         e_n;
  logic [1:0] g_op [0:99];
  logic [7:0] g_by [0:99];
  logic       g_nk [0:99];
  int         g_n = 0;
  logic [7:0] rsp  [0:63];
  logic [7:0] e_rdv [0:39];
  int         e_rdn;
  logic [7:0] g_rdv [0:39];
  int         g_rdn = 0, g_idx_bad = 0;
  int         rp = 0, erp, eng_wc = 0, ewc, nack_at = -1;
  bit         trunc;
  int         exp_err, exp_ph;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d (0x%0h) exp %0d (0x%0h)",
               tag, what, got, got, expv, expv);
    end
  endtask

  // model bit engine
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (p_done) p_done = 1'b0;
      else if (rst_n && p_req) begin
        if (dly > 0) dly--;
        else begin
          if (g_n < 100) begin
            g_op[g_n] = p_op; g_by[g_n] = p_wdata; g_nk[g_n] = p_nack;
          end
          g_n++;
          p_ack = 1'b1;
          if (p_op == 2'd2) begin
            p_ack = !(eng_wc == nack_at);
            eng_wc++;
          end else if (p_op == 2'd3) begin
            p_rdata = rsp[rp[5:0]];
            rp++;
          end
          p_done = 1'b1;
          dly = $urandom % 3;
        end
      end
    end
  end

  // read port monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (int'(rd_idx) != g_rdn) g_idx_bad++;
        if (g_rdn < 40) g_rdv[g_rdn] = rd_data;
        g_rdn++;
      end
    end
  end

  // expected-frame builders
  task automatic e_push(input logic [1:0] o, input logic [7:0] b, input logic nk);
    if (e_n < 100) begin e_op[e_n] = o; e_by[e_n] = b; e_nk[e_n] = nk; end
    e_n++;
  endtask
  task automatic e_start(); if (!trunc) e_push(2'd0, 8'h00, 1'b0); endtask
  task automatic e_stop();  if (!trunc) e_push(2'd1, 8'h00, 1'b0); endtask
  task automatic e_wr(input logic [7:0] b, input int cat);
    if (!trunc) begin
      e_push(2'd2, b, 1'b0);
      if (ewc == nack_at) begin
        trunc = 1'b1; exp_err = 1; exp_ph = cat;
        e_push(2'd1, 8'h00, 1'b0);
      end
      ewc++;
    end
  endtask
  task automatic e_rd(input logic last, input bit is_cnt);
    if (!trunc) begin
      e_push(2'd3, 8'h00, last);
      if (!is_cnt) begin e_rdv[e_rdn] = rsp[erp[5:0]]; e_rdn++; end
      erp++;
    end
  endtask
  task automatic e_reads(input int n);
    for (int i = 0; i < n; i++) e_rd(i == n - 1, 1'b0);
  endtask

  task automatic build(input int pr, input int len, input bit two);
    int lw, lr, c;
    logic [7:0] aw, ar;
    e_n = 0; e_rdn = 0; erp = 0; ewc = 0; trunc = 1'b0; exp_err = 0; exp_ph = 0;
    lw = (len > MAXB) ? MAXB : len;
    lr = (lw == 0) ? 1 : lw;
    aw = {t_addr, 1'b0};
    ar = {t_addr, 1'b1};
    e_start();
    case (pr)
      0: e_wr({t_addr, t_wdata[0]}, 1);
      1: begin e_wr(ar, 1); e_reads(1); end
      2: begin e_wr(aw, 1); e_wr(t_wdata[7:0], 3); end
      3, 4: begin
        e_wr(aw, 1); e_wr(t_code, 2); e_start(); e_wr(ar, 1);
        e_reads(pr == 4 ? 2 : 1);
      end
      5, 6: begin
        e_wr(aw, 1); e_wr(t_code, 2); e_wr(t_wdata[7:0], 3);
        if (pr == 6) e_wr(t_wdata[15:8], 3);
      end
      7: begin
        e_wr(aw, 1); e_wr(t_code, 2); e_wr(t_wdata[7:0], 3); e_wr(t_wdata[15:8], 3);
        e_start(); e_wr(ar, 1); e_reads(2);
      end
      8: begin
        e_wr(aw, 1); e_wr(t_code, 2); e_start(); e_wr(ar, 1);
        c = int'(rsp[0]);
        e_rd(1'b0, 1'b1);
        e_reads(c == 0 ? 1 : (c > MAXB ? MAXB : c));
      end
      9: begin
        e_wr(aw, 1); e_wr(t_code, 2); e_wr(8'(lw), 3);
        for (int k = 0; k < lw; k++) e_wr(t_wdata[8*k +: 8], 3);
      end
      10: begin
        e_wr(aw, 1); e_wr(t_code, 2);
        if (two) e_wr(t_code2, 2);
        e_start(); e_wr(ar, 1); e_reads(lr);
      end
      default: begin
        e_wr(aw, 1); e_wr(t_code, 2);
        for (int k = 0; k < lw; k++) e_wr(t_wdata[8*k +: 8], 3);
      end
    endcase
    e_stop();
  endtask

  function automatic string tag_of(input int pr);
    case (pr)
      0, 1, 2:    return "R4";
      3, 4, 5, 6: return "R5";
      7:          return "R6";
      8:          return "R8";
      9:          return "R9";
      10:         return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic randomize_fields(input int pr);
    t_addr  = 7'($urandom);
    t_code  = 8'($urandom);
    t_code2 = 8'($urandom);
    for (int k = 0; k < MAXB / 4; k++) t_wdata[32*k +: 32] = $urandom;
    for (int k = 0; k < 64; k++) rsp[k] = 8'($urandom);
    if (pr == 8) rsp[0] = 8'($urandom % 45);
  endtask

  task automatic run(input int pr, input int len, input bit two, input int nk);
    string tg;
    int last_rd, k;
    bit got_done, seq_ok;
    tg = tag_of(pr);
    t_proto = 4'(pr); t_len = 8'(len); t_two = two;
    nack_at = nk;
    build(pr, len, two);
    @(negedge clk);
    g_n = 0; g_rdn = 0; g_idx_bad = 0; rp = 0; eng_wc = 0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1", "ready low while busy", int'(cmd_ready), 0);
    got_done = 1'b0;
    for (k = 0; k < 3000; k++) begin
      if (done) begin got_done = 1'b1; break; end
      @(negedge clk);
    end
    chk(got_done, tg, "completion pulse seen", int'(got_done), 1);
    chk(int'(err) == exp_err, exp_err ? "R12" : tg, "err flag", int'(err), exp_err);
    chk(int'(err_ph) == exp_ph, "R12", "err phase", int'(err_ph), exp_ph);
    @(negedge clk);
    chk(!done && cmd_ready, "R1", "single pulse and ready again",
        int'({done, cmd_ready}), 1);
    // operation list
    chk(g_n == e_n, exp_err ? "R12" : tg, "operation count", g_n, e_n);
    seq_ok = 1'b1;
    for (int i = 0; i < e_n && i < g_n && i < 100; i++) begin
      if (seq_ok && (g_op[i] != e_op[i] || (e_op[i] == 2'd2 && g_by[i] != e_by[i]))) begin
        seq_ok = 1'b0;
        $display("FAIL %s op %0d: got op %0d byte %h exp op %0d byte %h",
                 tg, i, g_op[i], g_by[i], e_op[i], e_by[i]);
      end
    end
    total++;
    if (!seq_ok) bad++;
    chk(g_n >= 2 && g_op[0] == 2'd0 && g_op[(g_n - 1) % 100] == 2'd1, "R2",
        "start first, stop last", int'(g_op[(g_n - 1) % 100]), 1);
    if (g_n > 1)
      chk(g_by[1] == {t_addr, (pr == 0) ? t_wdata[0] : (pr == 1)}, "R3",
          "first address byte", int'(g_by[1]),
          int'({t_addr, (pr == 0) ? t_wdata[0] : (pr == 1)}));
    // ACK/NACK on reads: only final read of the log NACKs
    last_rd = -1;
    for (int i = 0; i < g_n && i < 100; i++) if (g_op[i] == 2'd3) last_rd = i;
    for (int i = 0; i < g_n && i < 100; i++)
      if (g_op[i] == 2'd3)
        chk(g_nk[i] == (i == last_rd), "R7", "read ack/nack", int'(g_nk[i]),
            int'(i == last_rd));
    // delivered read bytes
    chk(g_rdn == e_rdn, "R13", "read byte count", g_rdn, e_rdn);
    chk(g_idx_bad == 0, "R13", "read index order", g_idx_bad, 0);
    for (int i = 0; i < e_rdn && i < g_rdn && i < 40; i++)
      chk(g_rdv[i] == e_rdv[i], (pr == 4 || pr == 7) ? "R5" : "R13",
          "read byte value", int'(g_rdv[i]), int'(e_rdv[i]));
  endtask

  initial begin
    int pr, ln, nk;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cmd_ready && !done && !p_req, "R1", "reset state",
        int'({cmd_ready, done, p_req}), 4);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    randomize_fields(0); t_wdata[0] = 1'b1; run(0, 0, 0, -1);
    randomize_fields(0); t_wdata[0] = 1'b0; run(0, 0, 0, -1);
    randomize_fields(1); run(1, 0, 0, -1);
    randomize_fields(6); run(6, 0, 0, -1);
    randomize_fields(4); run(4, 0, 0, -1);
    randomize_fields(7); run(7, 0, 0, -1);
    randomize_fields(8); rsp[0] = 8'd0;  run(8, 0, 0, -1);
    randomize_fields(8); rsp[0] = 8'd50; run(8, 0, 0, -1);
    randomize_fields(8); rsp[0] = 8'd32; run(8, 0, 0, -1);
    randomize_fields(9); run(9, 40, 0, -1);
    randomize_fields(9); run(9, 0, 0, -1);
    randomize_fields(10); run(10, 0, 1, -1);
    randomize_fields(10); run(10, 33, 0, -1);
    randomize_fields(11); run(11, 5, 0, -1);
    randomize_fields(4); run(4, 0, 0, 0);   // R12 address NACK
    randomize_fields(6); run(6, 0, 0, 3);   // R12 NACK on last word byte
    randomize_fields(9); run(9, 3, 0, 5);   // R12 NACK on last block byte
    randomize_fields(7); run(7, 0, 0, 4);   // R12 NACK on read address

    for (int n = 0; n < 250; n++) begin
      pr = $urandom % 12;
      ln = $urandom % 41;
      nk = (($urandom % 5) == 0) ? int'($urandom % 12) : -1;
      randomize_fields(pr);
      run(pr, ln, 1'($urandom), nk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, got 0 exp 1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule